// File: doc/BRIEF.md
# Port-Controlled Bank-Switching Memory Mapper

This block sits between an 8-bit processor's address bus and the memory and I/O chips of the system. It looks at the upper address byte of every bus cycle and raises exactly one chip select. The candidates are the operating-system ROM, the BASIC ROM, the self-test ROM, the I/O region, a 128K static RAM and a 512K static RAM. For the two RAMs it also supplies the 16K bank number that forms the RAM's upper address bits, so the RAM address is `{ram_bank, A13..A0}`.

An 8-bit control register is held inside the block. It answers at page 0xD3 with A1:A0 = 01, so it appears at 0xD301 and its mirrors in that page. The CPU writes it to switch ROM overlays in and out and to choose which extended 16K bank shows through the window at 0x4000–0x7FFF. Reads of the register drive it onto the data bus through an output-enable, which models a tri-state buffer. A strap input picks the extended layout. In 320K mode there are 16 extended banks and bit 1 switches BASIC. In 576K mode there are 32 extended banks, bit 1 becomes the top bank bit, and BASIC can no longer be switched in. The first four extended banks live in the upper half of the 128K RAM. Every higher extended bank comes from the 512K RAM.

All bus-side pins are plain control pins. The block has no data stream and no handshake. A cycle is qualified by `bus_en`. A register write takes effect at the clock edge that ends the cycle, and the decode in the next cycle uses the new value.

Top module: `port_bank_mapper`

## Requirements
- R1: On reset the control register holds 0xFF, so the OS ROM is on, BASIC is off, self-test is off and base RAM sits in the window. A register read right after reset returns 0xFF.
- R2: A qualified write with page 0xD3 and A1:A0 = 01 loads `data_in` into the register at that clock edge. A qualified read at that address raises `data_oe` with `data_out` equal to the register. `data_oe` stays low in every other cycle, and no other cycle changes the register.
- R3: In the region 0xD000–0xD7FF a qualified cycle raises `cs_io`, except when it hits the register, and it never selects RAM or ROM there. The register hit raises no chip select.
- R4: With bit 0 = 1, accesses to 0xC000–0xCFFF and 0xD800–0xFFFF select the OS ROM. With bit 0 = 0 they select the 128K RAM, bank 3.
- R5: In 320K mode (`mode_576` = 0) with bit 1 = 0, 0xA000–0xBFFF selects the BASIC ROM. Otherwise, and always in 576K mode, that range selects 128K RAM bank 2.
- R6: With bit 7 = 0 and bit 0 = 1, 0x5000–0x57FF selects the self-test ROM. If either condition fails, the range behaves as part of the window.
- R7: With bit 4 = 1, the window 0x4000–0x7FFF maps to 128K RAM bank 1. With bit 4 = 0 it maps to the extended bank.
- R8: The extended index is {b6,b5,b3,b2} in 320K mode and {b1,b6,b5,b3,b2} in 576K mode, with b2 the least significant bit. An index below 4 selects the 128K RAM with `ram_bank` = 4 + index. An index of 4 or more selects the 512K RAM with `ram_bank` = index.
- R9: Outside the window, a base RAM access uses the 128K RAM with `ram_bank` = A15:A14. `ram_bank` is 0 when no RAM is selected. With `bus_en` = 1 and no register hit, exactly one chip select is high. With `bus_en` = 0 none is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Qualifies the current bus cycle |
| rw | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 8 | Address bits A15..A8 |
| addr_lo | input | 2 | Address bits A1..A0 |
| data_in | input | 8 | CPU write data |
| mode_576 | input | 1 | Strap: 1 = 576K layout, 0 = 320K layout |
| data_out | output | 8 | Register read data |
| data_oe | output | 1 | Drive enable for `data_out` |
| cs_os | output | 1 | OS ROM select |
| cs_basic | output | 1 | BASIC ROM select |
| cs_selftest | output | 1 | Self-test ROM select |
| cs_io | output | 1 | I/O region select |
| cs_ram128 | output | 1 | 128K RAM select |
| cs_ram512 | output | 1 | 512K RAM select |
| ram_bank | output | 5 | 16K bank number for the selected RAM |

## Verification
The bench goes after the places where two overlays fight for the same page. One is the self-test range with the OS ROM switched off: a design that ignored bit 0 there would show self-test ROM in place of window RAM. Another is the BASIC range in 576K mode, where a design that kept bit 1 as a BASIC enable would hide RAM. A third is the register page at A1:A0 other than 01, where a sloppy decode would swallow ordinary I/O cycles. Extended indices 3 and 4 sit on the boundary between the two RAMs, so an off-by-one there sends bank traffic to the wrong chip. Random traffic with random register values then checks that exactly one select fires and that no stray cycle alters the register.

// File: rtl/bank_mapper_pkg.sv
`timescale 1ns/1ps
package bank_mapper_pkg;
  localparam int CTRL_W = 8;
  localparam int PAGE_W = 8;
  localparam int LOW_W  = 2;
  localparam int BANK_W = 5;

  // control bit positions
  localparam int OS_BIT    = 0;
  localparam int BASIC_BIT = 1;
  localparam int EXT_B0    = 2;
  localparam int EXT_B1    = 3;
  localparam int WIN_BIT   = 4;
  localparam int EXT_B2    = 5;
  localparam int EXT_B3    = 6;
  localparam int ST_BIT    = 7;

  // number of extended banks kept in the 128K part
  localparam int LOCAL_EXT = 4;

  typedef struct packed {
    logic io;
    logic os_rom;
    logic basic;
    logic selftest;
    logic window;
  } region_t;
endpackage

// File: rtl/mapper_ctrl_reg.sv
`timescale 1ns/1ps
module mapper_ctrl_reg
  import bank_mapper_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RESET_VAL = 8'hFF,
  parameter logic [PAGE_W-1:0] REG_PAGE  = 8'hD3,
  parameter logic [LOW_W-1:0]  REG_LOW   = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              rw,
  input  logic [PAGE_W-1:0] addr_hi,
  input  logic [LOW_W-1:0]  addr_lo,
  input  logic [CTRL_W-1:0] data_in,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              reg_hit,
  output logic [CTRL_W-1:0] data_out,
  output logic              data_oe
);
  logic wr_en;

  assign reg_hit = (addr_hi == REG_PAGE) && (addr_lo == REG_LOW);
  assign wr_en   = bus_en && reg_hit && !rw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= RESET_VAL;
    else if (wr_en) ctrl_q <= data_in;
  end

  always_comb begin
    data_oe  = bus_en && reg_hit && rw;
    data_out = data_oe ? ctrl_q : '0;
  end
endmodule

// File: rtl/mapper_region_decode.sv
`timescale 1ns/1ps
module mapper_region_decode
  import bank_mapper_pkg::*;
(
  input  logic [PAGE_W-1:0] addr_hi,
  output region_t           region
);
  always_comb begin
    region          = '0;
    region.io       = (addr_hi[7:3] == 5'b11010);                  // D000-D7FF
    region.os_rom   = (addr_hi[7:4] == 4'hC) || (addr_hi >= 8'hD8); // C000-CFFF, D800-FFFF
    region.basic    = (addr_hi[7:5] == 3'b101);                     // A000-BFFF
    region.selftest = (addr_hi[7:3] == 5'b01010);                   // 5000-57FF
    region.window   = (addr_hi[7:6] == 2'b01);                      // 4000-7FFF
  end
endmodule

// File: rtl/mapper_bank_select.sv
`timescale 1ns/1ps
module mapper_bank_select
  import bank_mapper_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              mode_576,
  input  logic [1:0]        addr_top,
  input  logic              in_window,
  output logic [BANK_W-1:0] bank,
  output logic              use_512
);
  localparam int EXT_BITS = 5;
  localparam int EXT_MAP [EXT_BITS-1] = '{EXT_B0, EXT_B1, EXT_B2, EXT_B3};

  logic [EXT_BITS-1:0] ext_idx;

  generate
    for (genvar i = 0; i < EXT_BITS - 1; i++) begin : g_ext
      assign ext_idx[i] = ctrl[EXT_MAP[i]];
    end
  endgenerate
  assign ext_idx[EXT_BITS-1] = mode_576 & ctrl[BASIC_BIT];

  always_comb begin
    use_512 = 1'b0;
    bank    = {{(BANK_W-2){1'b0}}, addr_top};
    if (in_window && !ctrl[WIN_BIT]) begin
      if (ext_idx < EXT_BITS'(LOCAL_EXT)) begin
        bank = BANK_W'(LOCAL_EXT) + BANK_W'(ext_idx);
      end else begin
        bank    = BANK_W'(ext_idx);
        use_512 = 1'b1;
      end
    end
  end
endmodule

// File: rtl/port_bank_mapper.sv
`timescale 1ns/1ps
module port_bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter logic [CTRL_W-1:0] RESET_VAL = 8'hFF,
  parameter logic [PAGE_W-1:0] REG_PAGE  = 8'hD3,
  parameter logic [LOW_W-1:0]  REG_LOW   = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              rw,
  input  logic [PAGE_W-1:0] addr_hi,
  input  logic [LOW_W-1:0]  addr_lo,
  input  logic [CTRL_W-1:0] data_in,
  input  logic              mode_576,
  output logic [CTRL_W-1:0] data_out,
  output logic              data_oe,
  output logic              cs_os,
  output logic              cs_basic,
  output logic              cs_selftest,
  output logic              cs_io,
  output logic              cs_ram128,
  output logic              cs_ram512,
  output logic [BANK_W-1:0] ram_bank
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              reg_hit;
  region_t           region;
  logic [BANK_W-1:0] bank;
  logic              use_512;
  logic              os_on, basic_on, st_on, io_on, ram_on;

  mapper_ctrl_reg #(
    .RESET_VAL(RESET_VAL), .REG_PAGE(REG_PAGE), .REG_LOW(REG_LOW)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .rw(rw),
    .addr_hi(addr_hi), .addr_lo(addr_lo), .data_in(data_in),
    .ctrl_q(ctrl_q), .reg_hit(reg_hit), .data_out(data_out), .data_oe(data_oe)
  );

  mapper_region_decode i_region (
    .addr_hi(addr_hi), .region(region)
  );

  mapper_bank_select i_bank (
    .ctrl(ctrl_q), .mode_576(mode_576), .addr_top(addr_hi[7:6]),
    .in_window(region.window && !st_on), .bank(bank), .use_512(use_512)
  );

  always_comb begin
    io_on    = region.io && !reg_hit;
    os_on    = region.os_rom && ctrl_q[OS_BIT];
    basic_on = region.basic && !mode_576 && !ctrl_q[BASIC_BIT];
    st_on    = region.selftest && ctrl_q[OS_BIT] && !ctrl_q[ST_BIT];
    ram_on   = !(io_on || os_on || basic_on || st_on || reg_hit);

    cs_io       = bus_en && io_on;
    cs_os       = bus_en && os_on;
    cs_basic    = bus_en && basic_on;
    cs_selftest = bus_en && st_on;
    cs_ram128   = bus_en && ram_on && !use_512;
    cs_ram512   = bus_en && ram_on && use_512;
    ram_bank    = (bus_en && ram_on) ? bank : '0;
  end
endmodule

// File: rtl/bank_mapper_checker.sv
`timescale 1ns/1ps
module bank_mapper_checker
  import bank_mapper_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              rw,
  input logic [PAGE_W-1:0] addr_hi,
  input logic [LOW_W-1:0]  addr_lo,
  input logic [CTRL_W-1:0] data_in,
  input logic              mode_576,
  input logic              data_oe,
  input logic              cs_os,
  input logic              cs_basic,
  input logic              cs_selftest,
  input logic              cs_io,
  input logic              cs_ram128,
  input logic              cs_ram512,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic              reg_hit
);
  logic [5:0] sel;
  logic       wr_hit;
  assign sel    = {cs_os, cs_basic, cs_selftest, cs_io, cs_ram128, cs_ram512};
  assign wr_hit = bus_en && reg_hit && !rw;

  assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ctrl_q == $past(data_in));

  assert_reg_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctrl_q));

  assert_oe_only_on_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (bus_en && rw && addr_hi == 8'hD3 && addr_lo == 2'b01));

  assert_io_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && addr_hi[7:3] == 5'b11010 && addr_lo != 2'b01) |-> cs_io);

  assert_no_basic_576_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_576 |-> !cs_basic);

  assert_selftest_needs_os_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_selftest |-> (ctrl_q[OS_BIT] && !ctrl_q[ST_BIT]));

  assert_one_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !reg_hit) |-> $countones(sel) == 1);

  assert_idle_no_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |-> sel == 6'b0);
endmodule

bind port_bank_mapper bank_mapper_checker i_checker (.*);

// File: tb/test_port_bank_mapper.sv
`timescale 1ns/1ps
module test_port_bank_mapper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_en = 1'b0;
  logic       rw = 1'b1;
  logic [7:0] addr_hi = 8'h00;
  logic [1:0] addr_lo = 2'b00;
  logic [7:0] data_in = 8'h00;
  logic       mode_576 = 1'b0;
  logic [7:0] data_out;
  logic       data_oe;
  logic       cs_os, cs_basic, cs_selftest, cs_io, cs_ram128, cs_ram512;
  logic [4:0] ram_bank;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow = 8'hFF;

  always #4 clk = ~clk;

  port_bank_mapper i_port_bank_mapper (.*);

  // expected {io,os,basic,st,r128,r512,bank[4:0]} from the requirements
  function automatic logic [10:0] model(logic [7:0] hi, logic [1:0] lo, logic en,
                                        logic [7:0] c, logic m);
    logic io, os, bas, st, win, ram, big, hit;
    logic [4:0] idx, bk;
    hit = (hi == 8'hD3) && (lo == 2'b01);
    io  = (hi >= 8'hD0 && hi <= 8'hD7) && !hit;
    os  = ((hi >= 8'hC0 && hi <= 8'hCF) || hi >= 8'hD8) && c[0];
    bas = (hi >= 8'hA0 && hi <= 8'hBF) && !m && !c[1];
    st  = (hi >= 8'h50 && hi <= 8'h57) && c[0] && !c[7];
    win = (hi >= 8'h40 && hi <= 8'h7F) && !st;
    ram = !(io || os || bas || st || hit);
    idx = {m & c[1], c[6], c[5], c[3], c[2]};
    big = 1'b0;
    bk  = {3'b000, hi[7:6]};
    if (win && !c[4]) begin
      if (idx < 5'd4) bk = 5'd4 + idx;
      else begin bk = idx; big = 1'b1; end
    end
    if (!en) return 11'd0;
    return {io, os, bas, st, ram && !big, ram && big, ram ? bk : 5'd0};
  endfunction

  function automatic string req_of(logic [7:0] hi);
    if (hi >= 8'hD0 && hi <= 8'hD7) return "R3";
    if (hi >= 8'hC0) return "R4";
    if (hi >= 8'hA0 && hi <= 8'hBF) return "R5";
    if (hi >= 8'h50 && hi <= 8'h57) return "R6";
    if (hi >= 8'h40 && hi <= 8'h7F) return "R8";
    return "R9";
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one bus cycle; checks selects and read data, tracks register writes
  task automatic cycle(string req, logic en, logic r, logic [7:0] hi, logic [1:0] lo,
                       logic [7:0] d);
    logic hit;
    @(negedge clk);
    bus_en = en; rw = r; addr_hi = hi; addr_lo = lo; data_in = d;
    #2;
    hit = (hi == 8'hD3) && (lo == 2'b01);
    check(req, "selects",
          {cs_io, cs_os, cs_basic, cs_selftest, cs_ram128, cs_ram512, ram_bank},
          model(hi, lo, en, shadow, mode_576));
    check(req, "data_oe", data_oe, en && r && hit);
    if (en && r && hit) check(req, "data_out", data_out, shadow);
    if (en && !r && hit) shadow = d;
  endtask

  task automatic wr(logic [7:0] d);
    cycle("R2", 1'b1, 1'b0, 8'hD3, 2'b01, d);
  endtask

  task automatic rd(string req);
    cycle(req, 1'b1, 1'b1, 8'hD3, 2'b01, 8'h00);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset value read back, OS on, BASIC off, base window
    rd("R1");
    cycle("R1", 1'b1, 1'b1, 8'hE0, 2'b00, 8'h00);
    cycle("R1", 1'b1, 1'b1, 8'hA5, 2'b00, 8'h00);
    cycle("R1", 1'b1, 1'b1, 8'h45, 2'b00, 8'h00);

    // R2: write then read back; near-miss address leaves register alone
    wr(8'h5A); rd("R2");
    cycle("R2", 1'b1, 1'b0, 8'hD3, 2'b00, 8'h00);
    cycle("R2", 1'b0, 1'b0, 8'hD3, 2'b01, 8'h00);
    rd("R2");

    // R3: I/O page near the register, read and write
    cycle("R3", 1'b1, 1'b1, 8'hD3, 2'b10, 8'h00);
    cycle("R3", 1'b1, 1'b0, 8'hD0, 2'b01, 8'h00);
    cycle("R3", 1'b1, 1'b1, 8'hD7, 2'b11, 8'h00);

    // R4: OS off exposes RAM bank 3, OS on restores ROM
    wr(8'hFE);
    cycle("R4", 1'b1, 1'b1, 8'hC0, 2'b00, 8'h00);
    cycle("R4", 1'b1, 1'b1, 8'hFF, 2'b00, 8'h00);
    cycle("R4", 1'b1, 1'b1, 8'hD8, 2'b00, 8'h00);
    // R6: self-test requested but OS off -> window RAM
    wr(8'h7E);
    cycle("R6", 1'b1, 1'b1, 8'h52, 2'b00, 8'h00);
    wr(8'h7F);
    cycle("R6", 1'b1, 1'b1, 8'h57, 2'b00, 8'h00);
    cycle("R6", 1'b1, 1'b1, 8'h58, 2'b00, 8'h00);

    // R5: BASIC in 320K mode, then 576K mode forbids it
    wr(8'hFD);
    cycle("R5", 1'b1, 1'b1, 8'hA0, 2'b00, 8'h00);
    cycle("R5", 1'b1, 1'b1, 8'hBF, 2'b00, 8'h00);
    mode_576 = 1'b1;
    cycle("R5", 1'b1, 1'b1, 8'hA0, 2'b00, 8'h00);
    mode_576 = 1'b0;

    // R7: window base vs extended
    wr(8'hFF);
    cycle("R7", 1'b1, 1'b1, 8'h60, 2'b00, 8'h00);
    wr(8'hEF);
    cycle("R7", 1'b1, 1'b1, 8'h60, 2'b00, 8'h00);

    // R8: index boundaries 3 and 4 in both modes
    wr(8'b1000_1101); cycle("R8", 1'b1, 1'b1, 8'h40, 2'b00, 8'h00); // idx 3
    wr(8'b1010_0001); cycle("R8", 1'b1, 1'b1, 8'h7F, 2'b00, 8'h00); // idx 4
    wr(8'b1100_0001); cycle("R8", 1'b1, 1'b1, 8'h44, 2'b00, 8'h00); // idx 8
    mode_576 = 1'b1;
    wr(8'b1000_0011); cycle("R8", 1'b1, 1'b1, 8'h44, 2'b00, 8'h00); // idx 16
    wr(8'b1110_1111); cycle("R8", 1'b1, 1'b1, 8'h44, 2'b00, 8'h00); // idx 31
    mode_576 = 1'b0;

    // R9: idle cycles select nothing; base RAM below window
    cycle("R9", 1'b0, 1'b1, 8'h10, 2'b00, 8'h00);
    cycle("R9", 1'b0, 1'b1, 8'hE0, 2'b00, 8'h00);
    cycle("R9", 1'b1, 1'b1, 8'h10, 2'b00, 8'h00);
    cycle("R9", 1'b1, 1'b1, 8'h90, 2'b00, 8'h00);

    // random mix
    for (int n = 0; n < 2000; n++) begin
      int unsigned pick = $urandom_range(0, 99);
      logic [7:0] hi = 8'($urandom);
      logic [1:0] lo = 2'($urandom);
      if (pick < 3) mode_576 = ~mode_576;
      if (pick < 20) wr(8'($urandom));
      else if (pick < 28) rd("R2");
      else begin
        if (pick < 35) hi = 8'hD3;
        cycle(req_of(hi), pick < 95, 1'($urandom), hi, lo, 8'($urandom));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule